// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block lets an external host read and write a bank of 128 eight-bit registers over four serial pins: an active-low select, a serial clock, a data input and a data output that can float. Each access is a single 16-bit frame made of one direction bit, a 7-bit address and one data byte. Address and data both travel least significant bit first.

The serial pins are never used as clocks. Each one passes through a two-flop synchronizer in the faster system clock domain. Serial clock edges are then found from the synchronized level. Incoming bits are always captured on a rising serial edge. A static edge-select pin chooses whether read data moves on the rising or on the falling serial edge. The output floats whenever it is not returning read data.

Top module: `ser_reg_port`

## Requirements
- R1: A synchronous active-high reset clears every register to zero, returns the frame logic to idle and leaves the data output undriven (`sdo_oe` = 0).
- R2: A frame is bit 0 = direction (1 = read, 0 = write), then address bits A0..A6, then data bits D0..D7, each field least significant bit first. All bits are captured on rising serial clock edges.
- R3: A write frame stores the received byte into the addressed register only after all eight data bits have arrived with select still low.
- R4: A read frame returns the addressed register's contents on `sdo`, D0 first, one bit per output edge.
- R5: With `edge_sel` = 0, read data changes only after rising serial clock edges and holds across falling edges.
- R6: With `edge_sel` = 1, read data changes only after falling serial clock edges and holds across rising edges.
- R7: `sdo_oe` is 0 while select is high and throughout the direction and address bits. It returns to 0 after select rises.
- R8: When select rises mid-frame, the partial frame is discarded with no register change, and the next frame is decoded from its first bit.
- R9: A write changes only the addressed register. Other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples all serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| edge_sel | input | 1 | Read-data edge: 0 rising, 1 falling |
| sdo | output | 1 | Serial read data; high impedance when not driven |
| sdo_oe | output | 1 | Output enable for `sdo` |

## Verification
The in-RTL assertions check the following on every cycle: the output enable stays low while select is high and through the address phase, `sdo` holds between the selected output edges, reset silences the output and clears the bank, and a committed write lands in the bank. Other properties can be shown only by the bench's frames. These are the bit ordering of address and data, the value that comes back from each register, the discarding of a truncated write, and the fact that untouched registers keep their values. The bench drives whole frames at a serial rate well below the system clock and samples `sdo` in the half period before each capture.

// File: rtl/serp_pkg.sv
package serp_pkg;
   typedef enum logic [1:0] {
      FR_IDLE,
      FR_ADDR,
      FR_DATA,
      FR_DONE
   } frame_state_t;
endpackage

// File: rtl/serp_sync.sv
module serp_sync #(
   parameter int                WIDTH   = 3,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("serp_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("serp_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain[0] <= RST_VAL;
            else     chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain[s] <= RST_VAL;
            else     chain[s] <= chain[s-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/serp_edge.sv
module serp_edge (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic rise,
   output logic fall
);
   logic lvl_d;

   always_ff @(posedge clk) begin
      if (rst) lvl_d <= 1'b0;
      else     lvl_d <= lvl;
   end

   assign rise = lvl & ~lvl_d;
   assign fall = ~lvl & lvl_d;
endmodule

// File: rtl/serp_regbank.sv
module serp_regbank #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("serp_regbank: ADDR_W out of range 1..10");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (rst)
            mem[w] <= '0;
         else if (wr_en && wr_addr == ADDR_W'(w))
            mem[w] <= wr_data;
      end
   end

   assign rd_data = mem[rd_addr];

   assert_bank_clear_R1: assert property (@(posedge clk)
      rst |=> (mem[0] == '0 && mem[DEPTH-1] == '0));

   assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/serp_frame.sv
module serp_frame
   import serp_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_s,
   input  logic              sdi_s,
   input  logic              rise,
   input  logic              fall,
   input  logic              edge_sel,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              sdo_q,
   output logic              oe_q
);
   localparam int MAXF   = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
   localparam int CNT_W  = (MAXF > 1) ? $clog2(MAXF) : 1;
   localparam int OCNT_W = $clog2(DATA_W + 1);

   if (DATA_W < 2 || ADDR_W < 2) begin : g_bad_fields
      $error("serp_frame: ADDR_W and DATA_W must be at least 2");
   end

   frame_state_t      state;
   logic [CNT_W-1:0]  cnt;
   logic              dir_rd;
   logic [DATA_W-1:0] wd;
   logic [DATA_W-1:0] sh;
   logic              load;
   logic              rd_phase;
   logic [OCNT_W-1:0] ocnt;
   logic              wr_pend;
   logic              out_evt;

   assign out_evt = edge_sel ? fall : rise;

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= FR_IDLE;
         cnt      <= '0;
         dir_rd   <= 1'b0;
         addr     <= '0;
         wd       <= '0;
         sh       <= '0;
         load     <= 1'b0;
         rd_phase <= 1'b0;
         ocnt     <= '0;
         wr_pend  <= 1'b0;
         sdo_q    <= 1'b0;
         oe_q     <= 1'b0;
      end else begin
         wr_pend <= 1'b0;
         load    <= 1'b0;
         if (cs_s) begin
            state    <= FR_IDLE;
            cnt      <= '0;
            rd_phase <= 1'b0;
            ocnt     <= '0;
            oe_q     <= 1'b0;
         end else begin
            if (rise) begin
               case (state)
                  FR_IDLE: begin
                     dir_rd <= sdi_s;
                     cnt    <= '0;
                     state  <= FR_ADDR;
                  end
                  FR_ADDR: begin
                     addr <= {sdi_s, addr[ADDR_W-1:1]};
                     if (cnt == CNT_W'(ADDR_W - 1)) begin
                        cnt   <= '0;
                        state <= FR_DATA;
                        load  <= dir_rd;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  FR_DATA: begin
                     wd <= {sdi_s, wd[DATA_W-1:1]};
                     if (cnt == CNT_W'(DATA_W - 1)) begin
                        state   <= FR_DONE;
                        wr_pend <= ~dir_rd;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
            if (load) begin
               sh       <= rdata;
               rd_phase <= 1'b1;
            end
            if (out_evt && rd_phase && ocnt != OCNT_W'(DATA_W)) begin
               sdo_q <= sh[0];
               sh    <= sh >> 1;
               oe_q  <= 1'b1;
               ocnt  <= ocnt + 1'b1;
            end
         end
      end
   end

   assign wr_en   = wr_pend;
   assign wr_data = wd;

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> !oe_q);

   assert_float_cs_high_R7: assert property (@(posedge clk) disable iff (rst)
      cs_s |=> !oe_q);

   assert_float_addr_R7: assert property (@(posedge clk) disable iff (rst)
      (state == FR_IDLE || state == FR_ADDR) |-> !oe_q);

   assert_hold_rise_mode_R5: assert property (@(posedge clk) disable iff (rst)
      (!edge_sel && !rise) |=> $stable(sdo_q));

   assert_hold_fall_mode_R6: assert property (@(posedge clk) disable iff (rst)
      (edge_sel && !fall) |=> $stable(sdo_q));
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port #(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic cs_n,
   input  logic sclk,
   input  logic sdi,
   input  logic edge_sel,
   output logic sdo,
   output logic sdo_oe
);
   logic [2:0]        pins_s;
   logic              cs_s, sclk_s, sdi_s;
   logic              rise, fall;
   logic [ADDR_W-1:0] addr;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rdata;
   logic              sdo_q;
   logic              oe_q;

   serp_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  ({cs_n, sclk, sdi}),
      .dout (pins_s)
   );

   assign cs_s   = pins_s[2];
   assign sclk_s = pins_s[1];
   assign sdi_s  = pins_s[0];

   serp_edge u_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  (sclk_s),
      .rise (rise),
      .fall (fall)
   );

   serp_frame #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_frame (
      .clk      (clk),
      .rst      (rst),
      .cs_s     (cs_s),
      .sdi_s    (sdi_s),
      .rise     (rise),
      .fall     (fall),
      .edge_sel (edge_sel),
      .rdata    (rdata),
      .addr     (addr),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .sdo_q    (sdo_q),
      .oe_q     (oe_q)
   );

   serp_regbank #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (addr),
      .wr_data (wr_data),
      .rd_addr (addr),
      .rd_data (rdata)
   );

   assign sdo_oe = oe_q;
   assign sdo    = oe_q ? sdo_q : 1'bz;
endmodule

// File: tb/test_ser_reg_port.sv
module test_ser_reg_port;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cs_n = 1'b1;
   logic sclk = 1'b0;
   logic sdi = 1'b0;
   logic edge_sel = 1'b0;
   wire  sdo;
   wire  sdo_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ser_reg_port i_ser_reg_port (
      .clk      (clk),
      .rst      (rst),
      .cs_n     (cs_n),
      .sclk     (sclk),
      .sdi      (sdi),
      .edge_sel (edge_sel),
      .sdo      (sdo),
      .sdo_oe   (sdo_oe)
   );

   // fields: [16] read, [15] edge_sel, [14:8] address, [7:0] data / expected
   localparam logic [16:0] VECS [8] = '{
      {1'b0, 1'b0, 7'h00, 8'hA5},
      {1'b0, 1'b1, 7'h7F, 8'h3C},
      {1'b0, 1'b0, 7'h15, 8'h81},
      {1'b1, 1'b0, 7'h00, 8'hA5},
      {1'b1, 1'b1, 7'h7F, 8'h3C},
      {1'b1, 1'b0, 7'h15, 8'h81},
      {1'b1, 1'b1, 7'h15, 8'h81},
      {1'b1, 1'b0, 7'h2A, 8'h00}
   };

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic frame(input bit rd, input bit es, input logic [6:0] a,
                        input logic [7:0] d, input int nbits,
                        output logic [7:0] got, output bit oe_early,
                        output bit unstable, output bit oe_after);
      logic [15:0] bits;
      bits     = {d, a, rd};
      got      = '0;
      oe_early = 1'b0;
      unstable = 1'b0;
      edge_sel = es;
      cs_n     = 1'b0;
      hold(HALF);
      for (int i = 0; i < nbits; i++) begin
         sdi = bits[i];
         hold(HALF);
         if (i <= 7) oe_early |= sdo_oe;
         if (i >= 8 && es) got[i-8] = sdo;
         if (i >= 9 && !es && sdo !== got[i-9]) unstable = 1'b1;
         sclk = 1'b1;
         hold(HALF);
         if (i >= 8 && !es) got[i-8] = sdo;
         if (i >= 8 && es && sdo !== got[i-8]) unstable = 1'b1;
         sclk = 1'b0;
      end
      hold(HALF);
      cs_n = 1'b1;
      hold(2 * HALF);
      oe_after = sdo_oe;
   endtask

   task automatic read_check(input bit es, input logic [6:0] a,
                             input logic [7:0] exp, input string req);
      logic [7:0] got;
      bit e, u, o;
      frame(1'b1, es, a, 8'h00, 16, got, e, u, o);
      check(got == exp, req, got, exp);
      check(!e, "R7 oe during address", e, 0);
      check(!u, es ? "R6 hold across rise" : "R5 hold across fall", u, 0);
      check(!o, "R7 oe after select high", o, 0);
   endtask

   initial begin
      logic [7:0] got;
      bit e, u, o;
      hold(5);
      rst = 1'b0;
      hold(5);
      check(sdo_oe == 1'b0, "R1 oe after reset", sdo_oe, 0);
      read_check(1'b0, 7'h00, 8'h00, "R1 bank zero after reset");

      // vector table: writes then readbacks (R2 R3 R4 R9)
      for (int v = 0; v < 8; v++) begin
         if (VECS[v][16])
            read_check(VECS[v][15], VECS[v][14:8], VECS[v][7:0], "R4 R2 readback");
         else
            frame(1'b0, VECS[v][15], VECS[v][14:8], VECS[v][7:0], 16, got, e, u, o);
      end

      // R8: write cut after 12 bits is discarded
      frame(1'b0, 1'b0, 7'h15, 8'hFF, 12, got, e, u, o);
      read_check(1'b0, 7'h15, 8'h81, "R8 truncated write discarded");

      // R8/R3: next full frame decodes from bit 0
      frame(1'b0, 1'b0, 7'h2A, 8'h5E, 16, got, e, u, o);
      read_check(1'b1, 7'h2A, 8'h5E, "R8 R3 frame after truncation");
      read_check(1'b0, 7'h00, 8'hA5, "R9 other register unchanged");

      // R1: reset clears bank
      rst = 1'b1;
      hold(3);
      rst = 1'b0;
      hold(5);
      check(sdo_oe == 1'b0, "R1 oe after second reset", sdo_oe, 0);
      read_check(1'b1, 7'h7F, 8'h00, "R1 bank cleared");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog all-requirements actual=timeout expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule